// File: doc/BRIEF.md
# Flash Byte Programming Sequencer

This block sequences parallel programming of a small on-chip code flash. A programmer presents an address, a data byte and a mode code, then pulses an active-low program strobe. The sequencer programs one byte per strobe and times the operation itself. It erases the whole array when the strobe is held low for long enough in erase mode. It returns fixed identification bytes in signature mode, and it can set two protection bits that hide the array from verify reads. The memory is behavioural and lives inside the block.

While a write is in progress, any read is a poll. The top data bit comes back inverted and the remaining bits come back as written, so the programmer can tell when the write has finished. A separate ready output is low for exactly the length of each self-timed operation. Programming can only clear bits. Only a chip erase brings bytes back to all ones and clears the protection bits.

The controller has five states. IDLE waits for a command. HOLD counts how long the strobe stays low in erase mode. WRITE is a self-timed byte program. LOCK is a self-timed protection-bit program. ERASE is a self-timed chip erase. The transitions are:
- IDLE to HOLD when the strobe is low in erase mode.
- IDLE to WRITE, or IDLE to LOCK, on a strobe rising edge in write or lock mode.
- HOLD to ERASE on a strobe rise once the low count has reached the threshold.
- HOLD to IDLE on an early rise, or when the mode leaves erase.
- WRITE, LOCK and ERASE to IDLE when their cycle counter expires.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset every byte of the array reads FFh in verify mode, and `ready` is high.
- R2: In write mode (code 1), a rising edge of `prog_strobe_n` starts a byte write. `ready` stays high while the strobe is low, then is low for exactly WRITE_CYC cycles starting with the cycle after the rising edge.
- R3: A completed write stores the bitwise AND of the old byte and the new data.
- R4: While a byte write is in progress, a read in verify mode (code 2) or signature mode (code 4) returns the written data with bit 7 inverted.
- R5: A strobe rising edge that arrives while the block is busy is dropped and changes no byte.
- R6: In erase mode (code 3), a strobe held low for at least ERASE_MIN sampled cycles and then released starts a chip erase. During the erase `ready` is low for exactly ERASE_CYC cycles and reads return 00h. Afterwards every byte is FFh and both protection bits are clear.
- R7: An erase strobe released before ERASE_MIN low cycles is ignored: `ready` stays high and the array is unchanged.
- R8: Signature mode returns 1Eh at address 030h, 51h at 031h, SIG_VOLT at 032h, and 00h at any other address.
- R9: In lock mode (code 5), a strobe rising edge programs protection bit `wdata[0]` as a self-timed operation of WRITE_CYC cycles. While either bit is set, verify reads return 00h. Signature reads are unaffected.
- R10: `rdata` is registered and reflects the mode and address of the previous cycle. Mode codes 0, 6 and 7 read 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address |
| wdata | input | DATA_W | Byte to program, or protection-bit select in lock mode |
| mode | input | 3 | Operation code: 0 none, 1 write, 2 verify, 3 erase, 4 signature, 5 lock |
| prog_strobe_n | input | 1 | Active-low program strobe |
| rdata | output | DATA_W | Registered read data |
| ready | output | 1 | High when idle, low while an operation runs |

## Verification
The bench measures busy length to the cycle on writes and erases. An off-by-one counter would shorten or lengthen `ready` low and give the programmer a wrong completion time. It reads during a write in both read modes, which catches a poll that returns raw or stale data. It also rewrites a programmed byte, which exposes a write that overwrites instead of clearing bits. Short erase pulses, strobes issued while busy, and verify reads under each protection bit are each followed by reads. A design that erased too eagerly, accepted queued commands, or leaked locked contents would then show wrong data.

// File: rtl/flash_pkg.sv
package flash_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_WRITE,
        ST_LOCK,
        ST_ERASE
    } fsm_state_t;

    localparam logic [2:0] MD_NONE   = 3'd0;
    localparam logic [2:0] MD_WRITE  = 3'd1;
    localparam logic [2:0] MD_VERIFY = 3'd2;
    localparam logic [2:0] MD_ERASE  = 3'd3;
    localparam logic [2:0] MD_SIG    = 3'd4;
    localparam logic [2:0] MD_LOCK   = 3'd5;

    localparam int SIG_ADDR_MAKER = 'h030;
    localparam int SIG_ADDR_PART  = 'h031;
    localparam int SIG_ADDR_VOLT  = 'h032;
    localparam logic [7:0] SIG_MAKER = 8'h1E;
    localparam logic [7:0] SIG_PART  = 8'h51;

    localparam int LOCK_BITS = 2;

endpackage

// File: rtl/flash_array.sv
module flash_array #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              erase_all,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Programming can only clear bits; erase returns all cells to ones.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (erase_all) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (wr_en) begin
            mem[wr_addr] <= mem[wr_addr] & wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
    import flash_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 8,
    parameter int WRITE_CYC = 75000,
    parameter int ERASE_MIN = 500000,
    parameter int ERASE_CYC = 500000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           mode,
    input  logic                 strobe_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    din,
    output fsm_state_t           state,
    output logic                 arr_wr_en,
    output logic [ADDR_W-1:0]    lat_addr,
    output logic [DATA_W-1:0]    lat_data,
    output logic                 arr_erase,
    output logic [LOCK_BITS-1:0] lock_q,
    output logic                 ready
);
    localparam int BUSY_MAX = (WRITE_CYC > ERASE_CYC) ? WRITE_CYC : ERASE_CYC;
    localparam int CW       = $clog2(BUSY_MAX + 1);
    localparam int HW       = $clog2(ERASE_MIN + 1);

    fsm_state_t  nxt;
    logic        strobe_q;
    logic        strobe_rise;
    logic [CW-1:0] busy_cnt;
    logic [HW-1:0] hold_cnt;
    logic        hold_ok;
    logic        wr_done;
    logic        lk_done;
    logic        er_done;

    assign strobe_rise = strobe_n & ~strobe_q;
    assign hold_ok     = (hold_cnt >= HW'(ERASE_MIN));
    assign wr_done     = (state == ST_WRITE) && (busy_cnt == CW'(WRITE_CYC - 1));
    assign lk_done     = (state == ST_LOCK)  && (busy_cnt == CW'(WRITE_CYC - 1));
    assign er_done     = (state == ST_ERASE) && (busy_cnt == CW'(ERASE_CYC - 1));

    // Next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (mode == MD_ERASE && !strobe_n)       nxt = ST_HOLD;
                else if (strobe_rise && mode == MD_WRITE) nxt = ST_WRITE;
                else if (strobe_rise && mode == MD_LOCK)  nxt = ST_LOCK;
            end
            ST_HOLD: begin
                if (mode != MD_ERASE)  nxt = ST_IDLE;
                else if (strobe_n)     nxt = hold_ok ? ST_ERASE : ST_IDLE;
            end
            ST_WRITE: if (wr_done) nxt = ST_IDLE;
            ST_LOCK:  if (lk_done) nxt = ST_IDLE;
            ST_ERASE: if (er_done) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Counters, latches and protection bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_q <= 1'b1;
            busy_cnt <= '0;
            hold_cnt <= '0;
            lat_addr <= '0;
            lat_data <= '0;
            lock_q   <= '0;
        end else begin
            strobe_q <= strobe_n;

            if (nxt != state)
                busy_cnt <= '0;
            else if (state == ST_WRITE || state == ST_LOCK || state == ST_ERASE)
                busy_cnt <= busy_cnt + 1'b1;

            if (state == ST_IDLE && nxt == ST_HOLD)
                hold_cnt <= HW'(1);
            else if (state == ST_HOLD && !strobe_n && !hold_ok)
                hold_cnt <= hold_cnt + 1'b1;

            if (state == ST_IDLE && (nxt == ST_WRITE || nxt == ST_LOCK)) begin
                lat_addr <= addr;
                lat_data <= din;
            end

            if (er_done)
                lock_q <= '0;
            else if (lk_done)
                lock_q[lat_data[0]] <= 1'b1;
        end
    end

    // Outputs decoded from state
    always_comb begin
        ready     = 1'b1;
        arr_wr_en = 1'b0;
        arr_erase = 1'b0;
        unique case (state)
            ST_IDLE, ST_HOLD: ready = 1'b1;
            ST_WRITE: begin
                ready     = 1'b0;
                arr_wr_en = wr_done;
            end
            ST_LOCK:  ready = 1'b0;
            ST_ERASE: begin
                ready     = 1'b0;
                arr_erase = er_done;
            end
            default:  ready = 1'b1;
        endcase
    end

endmodule

// File: rtl/flash_read_mux.sv
module flash_read_mux
    import flash_pkg::*;
#(
    parameter int          ADDR_W   = 12,
    parameter int          DATA_W   = 8,
    parameter logic [7:0]  SIG_VOLT = 8'hFF
) (
    input  logic [2:0]        mode,
    input  logic [ADDR_W-1:0] addr,
    input  fsm_state_t        state,
    input  logic [DATA_W-1:0] lat_data,
    input  logic [DATA_W-1:0] arr_rd,
    input  logic              verify_blocked,
    output logic [DATA_W-1:0] rd_val
);
    logic [DATA_W-1:0] poll_val;

    always_comb begin
        poll_val             = lat_data;
        poll_val[DATA_W-1]   = ~lat_data[DATA_W-1];
    end

    always_comb begin
        rd_val = '0;
        if (state == ST_WRITE || state == ST_LOCK) begin
            if (mode == MD_VERIFY || mode == MD_SIG) rd_val = poll_val;
        end else if (state == ST_ERASE) begin
            rd_val = '0;
        end else begin
            unique case (mode)
                MD_VERIFY: rd_val = verify_blocked ? '0 : arr_rd;
                MD_SIG: begin
                    if (addr == ADDR_W'(SIG_ADDR_MAKER))     rd_val = DATA_W'(SIG_MAKER);
                    else if (addr == ADDR_W'(SIG_ADDR_PART)) rd_val = DATA_W'(SIG_PART);
                    else if (addr == ADDR_W'(SIG_ADDR_VOLT)) rd_val = DATA_W'(SIG_VOLT);
                    else                                     rd_val = '0;
                end
                default: rd_val = '0;
            endcase
        end
    end

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
    import flash_pkg::*;
#(
    parameter int         ADDR_W    = 12,
    parameter int         DATA_W    = 8,
    parameter int         WRITE_CYC = 75000,
    parameter int         ERASE_MIN = 500000,
    parameter int         ERASE_CYC = 500000,
    parameter logic [7:0] SIG_VOLT  = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [2:0]        mode,
    input  logic              prog_strobe_n,
    output logic [DATA_W-1:0] rdata,
    output logic              ready
);
    fsm_state_t           fsm_state;
    logic                 arr_wr_en;
    logic                 arr_erase;
    logic [ADDR_W-1:0]    lat_addr;
    logic [DATA_W-1:0]    lat_data;
    logic [LOCK_BITS-1:0] lock_q;
    logic [DATA_W-1:0]    arr_rd;
    logic [DATA_W-1:0]    rd_val;

    flash_seq_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WRITE_CYC(WRITE_CYC),
        .ERASE_MIN(ERASE_MIN), .ERASE_CYC(ERASE_CYC)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .strobe_n(prog_strobe_n),
        .addr(addr), .din(wdata), .state(fsm_state), .arr_wr_en(arr_wr_en),
        .lat_addr(lat_addr), .lat_data(lat_data), .arr_erase(arr_erase),
        .lock_q(lock_q), .ready(ready)
    );

    flash_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) array_i (
        .clk(clk), .rst_n(rst_n), .wr_en(arr_wr_en), .wr_addr(lat_addr),
        .wr_data(lat_data), .erase_all(arr_erase), .rd_addr(addr), .rd_data(arr_rd)
    );

    flash_read_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIG_VOLT(SIG_VOLT)) mux_i (
        .mode(mode), .addr(addr), .state(fsm_state), .lat_data(lat_data),
        .arr_rd(arr_rd), .verify_blocked(|lock_q), .rd_val(rd_val)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= rd_val;
    end

endmodule

// File: rtl/flash_prog_seq_chk.sv
module flash_prog_seq_chk
    import flash_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 8,
    parameter int WRITE_CYC = 75000,
    parameter int ERASE_CYC = 500000
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [2:0]           mode,
    input logic [ADDR_W-1:0]    addr,
    input logic                 strobe_n,
    input logic                 ready,
    input logic [DATA_W-1:0]    rdata,
    input fsm_state_t           fsm_state,
    input logic [DATA_W-1:0]    lat_data,
    input logic [LOCK_BITS-1:0] lock_q
);
    localparam int BUSY_MAX = (WRITE_CYC > ERASE_CYC) ? WRITE_CYC : ERASE_CYC;

    logic [31:0] busy_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     busy_run <= '0;
        else if (ready) busy_run <= '0;
        else            busy_run <= busy_run + 1;
    end

    // R2
    write_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(strobe_n) && mode == MD_WRITE && ready) |=> !ready);

    // R2
    busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= BUSY_MAX);

    // R4
    poll_bit7_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fsm_state) == ST_WRITE && $past(mode) == MD_VERIFY)
        |-> (rdata[DATA_W-1] == ~$past(lat_data[DATA_W-1])));

    // R8
    sig_part_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ready && mode == MD_SIG && addr == ADDR_W'(SIG_ADDR_PART))
        |-> rdata == DATA_W'(SIG_PART));

    // R9
    lock_hide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ready && mode == MD_VERIFY && (|lock_q)) |-> rdata == '0);

    // R6
    erase_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fsm_state == ST_ERASE) |-> rdata == '0);

endmodule

bind flash_prog_seq flash_prog_seq_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WRITE_CYC(WRITE_CYC), .ERASE_CYC(ERASE_CYC)
) chk_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .addr(addr), .strobe_n(prog_strobe_n),
    .ready(ready), .rdata(rdata), .fsm_state(fsm_state), .lat_data(lat_data),
    .lock_q(lock_q)
);

// File: tb/flash_prog_seq_tb.sv
module flash_prog_seq_tb_top;
    localparam int W_CYC = 20;
    localparam int E_MIN = 40;
    localparam int E_CYC = 30;

    localparam logic [2:0] M_NONE = 3'd0, M_WR = 3'd1, M_VER = 3'd2,
                           M_ER = 3'd3, M_SIG = 3'd4, M_LK = 3'd5;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] addr;
    logic [7:0]  wdata;
    logic [2:0]  mode;
    logic        strobe_n;
    logic [7:0]  rdata;
    logic        ready;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct {
        logic [7:0] exp;
        int         due;
        string      tag;
    } exp_t;
    exp_t sbq[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc++;

    flash_prog_seq #(
        .WRITE_CYC(W_CYC), .ERASE_MIN(E_MIN), .ERASE_CYC(E_CYC), .SIG_VOLT(8'hFF)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .mode(mode),
        .prog_strobe_n(strobe_n), .rdata(rdata), .ready(ready)
    );

    // Monitor: pop expected read results when they fall due
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            exp_t it;
            it = sbq.pop_front();
            checks++;
            if (rdata !== it.exp) begin
                errors++;
                $display("FAIL %s rdata actual %h expected %h", it.tag, rdata, it.exp);
            end
        end
    end

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] m, input logic [11:0] a,
                      input logic [7:0] e, input string tag);
        exp_t it;
        mode = m;
        addr = a;
        it.exp = e;
        it.due = cyc + 1;
        it.tag = tag;
        sbq.push_back(it);
        @(negedge clk);
    endtask

    // Drive a low pulse, release it, then return one negedge later
    task automatic pulse(input logic [2:0] m, input logic [11:0] a,
                         input logic [7:0] d, input int low_cyc, input bit chk_hi);
        mode = m;
        addr = a;
        wdata = d;
        strobe_n = 1'b0;
        for (int i = 0; i < low_cyc; i++) begin
            @(negedge clk);
            if (chk_hi) chk(ready, 1, "R2 ready high while strobe low");
        end
        strobe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!ready && n < 5000) begin
            @(negedge clk);
            if (!ready) n++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        rst_n = 1'b0;
        strobe_n = 1'b1;
        mode = M_NONE;
        addr = '0;
        wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(ready, 1, "R1 ready after reset");
        rd(M_VER, 12'h000, 8'hFF, "R1");
        rd(M_VER, 12'hFFF, 8'hFF, "R1");
        // R10 unused mode codes
        rd(3'd6, 12'h005, 8'h00, "R10");
        rd(M_NONE, 12'h005, 8'h00, "R10");

        // R2/R4 write with polling
        pulse(M_WR, 12'h005, 8'hA5, 1, 1);
        chk(ready, 0, "R2 busy after rise");
        rd(M_VER, 12'h005, 8'h25, "R4 verify poll");
        rd(M_SIG, 12'h030, 8'h25, "R4 signature poll");
        wait_ready(n);
        rd(M_VER, 12'h005, 8'hA5, "R2 data stored");

        // R3 AND semantics, R2 exact busy length
        pulse(M_WR, 12'h005, 8'h3C, 2, 1);
        wait_ready(n);
        chk(1 + n, W_CYC, "R2 busy length");
        rd(M_VER, 12'h005, 8'h24, "R3");

        // R5 command while busy dropped
        pulse(M_WR, 12'h007, 8'h00, 1, 0);
        pulse(M_WR, 12'h008, 8'h00, 1, 0);
        wait_ready(n);
        rd(M_VER, 12'h008, 8'hFF, "R5");
        rd(M_VER, 12'h007, 8'h00, "R5");

        // R8 signature
        rd(M_SIG, 12'h030, 8'h1E, "R8");
        rd(M_SIG, 12'h031, 8'h51, "R8");
        rd(M_SIG, 12'h032, 8'hFF, "R8");
        rd(M_SIG, 12'h033, 8'h00, "R8");

        // R7 short erase ignored
        pulse(M_ER, 12'h000, 8'h00, 10, 0);
        chk(ready, 1, "R7 ready after short erase");
        rd(M_VER, 12'h005, 8'h24, "R7");

        // R9 protection bit 1
        pulse(M_LK, 12'h000, 8'h01, 1, 0);
        wait_ready(n);
        chk(1 + n, W_CYC, "R9 lock busy length");
        rd(M_VER, 12'h005, 8'h00, "R9 verify hidden");
        rd(M_SIG, 12'h031, 8'h51, "R9 signature unaffected");

        // R6 full erase
        pulse(M_ER, 12'h000, 8'h00, E_MIN + 2, 0);
        chk(ready, 0, "R6 busy after erase");
        rd(M_VER, 12'h005, 8'h00, "R6 read during erase");
        wait_ready(n);
        chk(2 + n, E_CYC, "R6 erase length");
        rd(M_VER, 12'h005, 8'hFF, "R6");
        rd(M_VER, 12'h007, 8'hFF, "R6");

        // R9 protection bit 0
        pulse(M_WR, 12'h009, 8'h5A, 1, 0);
        wait_ready(n);
        rd(M_VER, 12'h009, 8'h5A, "R9 before lock");
        pulse(M_LK, 12'h000, 8'h00, 1, 0);
        wait_ready(n);
        rd(M_VER, 12'h009, 8'h00, "R9 bit0 hides");

        mode = M_NONE;
        repeat (3) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule